// File: doc/BRIEF.md
# DMA Channel Service Controller

This block runs the service of one DMA channel. Once the channel's device raises its request and the channel is not masked, the block opens a service. It keeps the service open or releases it according to the programmed transfer mode. Each transfer-done pulse from the bus sequencer moves the channel's current address one step and decrements its word count. The block watches for the count rolling over, and it reports the end of process when the count rolls over or when an external end-of-process input arrives.

Three service-length policies are supported. Single mode makes one transfer per service. Block mode keeps going after the service has started, whatever the request does, until the terminal count or an external end of process. Demand mode keeps going while the device holds its request and keeps the current address and count for the next service.

At the end of process the current values are reloaded from the base values if auto-initialization is enabled. If it is not enabled, a terminal count masks the channel until the channel is loaded again.

Top module: `dma_svc_ctrl`

## Requirements
- R1: After reset, svc_active_o, eop_o, tc_o and masked_o are 0, and cur_addr_o and cur_cnt_o are 0.
- R2: Each transfer-done pulse taken during a service decrements cur_cnt_o by one. It also steps cur_addr_o by one: up when addr_dec_i is 0, down when it is 1. The address wraps modulo 65536, so FFFFh plus one gives 0000h.
- R3: The terminal count occurs on a transfer taken while cur_cnt_o is 0000h, which means the count rolls over to FFFFh. A loaded count N therefore moves N+1 items. tc_o is set by that transfer and stays set until the next load_i.
- R4: In single mode (mode_i = 2'b00, and 2'b11 behaves the same way), svc_active_o falls in the cycle after the first transfer-done pulse of the service.
- R5: In block mode (mode_i = 2'b01), the service stays open after it starts even with req_i low. It closes only after a transfer that hits the terminal count or that carries eop_ext_i.
- R6: In demand mode (mode_i = 2'b10), the service closes after a transfer-done pulse that arrives while req_i is low, or after a transfer that ends the process. Current address and count are kept, so a later request resumes from them.
- R7: eop_o is high for exactly the cycle of the final transfer-done pulse, and only when that transfer hits the terminal count or carries eop_ext_i.
- R8: With autoinit_i at 1, the transfer that raises eop_o leaves cur_addr_o and cur_cnt_o equal to base_addr_i and base_cnt_i, and masked_o stays 0.
- R9: With autoinit_i at 0, the terminal count sets masked_o. A masked channel does not start a service on req_i until load_i clears the mask.
- R10: A service starts (svc_active_o goes to 1) on the clock edge after req_i is seen high while idle and unmasked. Transfer-done pulses while idle change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Device request for this channel |
| xfer_done_i | input | 1 | One-cycle pulse: one transfer has completed |
| eop_ext_i | input | 1 | External end of process, sampled with xfer_done_i |
| mode_i | input | 2 | 00 single, 01 block, 10 demand, 11 as single |
| addr_dec_i | input | 1 | 1 decrements the address, 0 increments it |
| autoinit_i | input | 1 | Reload from base values at end of process |
| load_i | input | 1 | Copy base values into current ones, clear tc_o and mask |
| base_addr_i | input | 16 | Base address |
| base_cnt_i | input | 16 | Base word count |
| svc_active_o | output | 1 | 1 while the service holds the bus; its fall releases the bus |
| cur_addr_o | output | 16 | Current address |
| cur_cnt_o | output | 16 | Current word count |
| tc_o | output | 1 | Sticky terminal-count flag |
| eop_o | output | 1 | End-of-process pulse with the final transfer |
| masked_o | output | 1 | Channel mask set by the terminal count |

## Verification
The hardest case to reach is a terminal count that lands together with an address wrap. Getting there takes a load whose address sits next to FFFFh and whose count runs out after the wrap. The stimulus loads FFFEh with count 2 and runs three block transfers with the request already dropped. This reaches the wrap, the rollover and the mask in one service, and a request afterwards confirms that the mask holds. A second corner is the demand resume after release. It is covered by lowering the request on a transfer and raising it again later.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;
  parameter int unsigned DMA_AW = 16;
  parameter int unsigned DMA_CW = 16;

  typedef logic [DMA_AW-1:0] addr_t;
  typedef logic [DMA_CW-1:0] cnt_t;

  typedef enum logic [1:0] {
    XM_SINGLE = 2'b00,
    XM_BLOCK  = 2'b01,
    XM_DEMAND = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  function automatic addr_t step_addr(input addr_t a, input logic dec);
    return dec ? addr_t'(a - addr_t'(1)) : addr_t'(a + addr_t'(1));
  endfunction

  function automatic cnt_t step_cnt(input cnt_t c);
    return cnt_t'(c - cnt_t'(1));
  endfunction

  function automatic logic will_roll(input cnt_t c);
    return (c == '0);
  endfunction
endpackage

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt
  import dma_svc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  reload_i,
  input  logic  step_i,
  input  logic  dec_i,
  input  addr_t base_addr_i,
  input  cnt_t  base_cnt_i,
  output addr_t cur_addr_o,
  output cnt_t  cur_cnt_o,
  output logic  rollover_o
);
  addr_t addr_q;
  cnt_t  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i || reload_i) begin
      addr_q <= base_addr_i;
      cnt_q  <= base_cnt_i;
    end else if (step_i) begin
      addr_q <= step_addr(addr_q, dec_i);
      cnt_q  <= step_cnt(cnt_q);
    end
  end

  assign cur_addr_o = addr_q;
  assign cur_cnt_o  = cnt_q;
  assign rollover_o = will_roll(cnt_q);

  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !reload_i && !load_i) |=> (cnt_q == cnt_t'($past(cnt_q) - 1'b1)));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !reload_i && !load_i && !dec_i) |=> (addr_q == addr_t'($past(addr_q) + 1'b1)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !reload_i && !load_i) |=> $stable(cnt_q) && $stable(addr_q));
endmodule

// File: rtl/dma_svc_fsm.sv
module dma_svc_fsm
  import dma_svc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       done_i,
  input  logic       eop_ext_i,
  input  logic [1:0] mode_i,
  input  logic       autoinit_i,
  input  logic       load_i,
  input  logic       rollover_i,
  output logic       svc_o,
  output logic       step_o,
  output logic       reload_o,
  output logic       eop_o,
  output logic       tc_o,
  output logic       masked_o
);
  xfer_mode_e mode;
  logic svc_q, mask_q, tc_q;
  logic tc_hit, last_xfer, start_svc;

  assign mode      = xfer_mode_e'(mode_i);
  assign step_o    = svc_q && done_i;
  assign tc_hit    = step_o && rollover_i;
  assign eop_o     = step_o && (rollover_i || eop_ext_i);
  assign reload_o  = eop_o && autoinit_i;
  assign start_svc = !svc_q && req_i && !mask_q && !load_i;

  always_comb begin
    unique case (mode)
      XM_BLOCK:  last_xfer = eop_o;
      XM_DEMAND: last_xfer = eop_o || !req_i;
      default:   last_xfer = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q  <= 1'b0;
      mask_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      if (start_svc)                 svc_q <= 1'b1;
      else if (step_o && last_xfer)  svc_q <= 1'b0;
      if (load_i) begin
        mask_q <= 1'b0;
        tc_q   <= 1'b0;
      end else if (tc_hit) begin
        tc_q <= 1'b1;
        if (!autoinit_i) mask_q <= 1'b1;
      end
    end
  end

  assign svc_o    = svc_q;
  assign tc_o     = tc_q;
  assign masked_o = mask_q;

  // R4
  single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && (mode == XM_SINGLE)) |=> !svc_q);

  // R5
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && (mode == XM_BLOCK) && !(done_i && (rollover_i || eop_ext_i))) |=> svc_q);

  // R7
  eop_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |-> (done_i && svc_q));

  // R9
  masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !svc_q && !load_i) |=> !svc_q);

  // R3
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && !load_i) |=> tc_q);
endmodule

// File: rtl/dma_svc_ctrl.sv
module dma_svc_ctrl
  import dma_svc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              xfer_done_i,
  input  logic              eop_ext_i,
  input  logic [1:0]        mode_i,
  input  logic              addr_dec_i,
  input  logic              autoinit_i,
  input  logic              load_i,
  input  logic [DMA_AW-1:0] base_addr_i,
  input  logic [DMA_CW-1:0] base_cnt_i,
  output logic              svc_active_o,
  output logic [DMA_AW-1:0] cur_addr_o,
  output logic [DMA_CW-1:0] cur_cnt_o,
  output logic              tc_o,
  output logic              eop_o,
  output logic              masked_o
);
  logic step_w, reload_w, rollover_w;

  dma_svc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .done_i     (xfer_done_i),
    .eop_ext_i  (eop_ext_i),
    .mode_i     (mode_i),
    .autoinit_i (autoinit_i),
    .load_i     (load_i),
    .rollover_i (rollover_w),
    .svc_o      (svc_active_o),
    .step_o     (step_w),
    .reload_o   (reload_w),
    .eop_o      (eop_o),
    .tc_o       (tc_o),
    .masked_o   (masked_o)
  );

  dma_addr_cnt u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .reload_i    (reload_w),
    .step_i      (step_w),
    .dec_i       (addr_dec_i),
    .base_addr_i (base_addr_i),
    .base_cnt_i  (base_cnt_i),
    .cur_addr_o  (cur_addr_o),
    .cur_cnt_o   (cur_cnt_o),
    .rollover_o  (rollover_w)
  );

  // R8
  autoinit_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_w && !load_i) |=> (cur_addr_o == $past(base_addr_i)) && (cur_cnt_o == $past(base_cnt_i)) && !masked_o);
endmodule

// File: tb/dma_svc_ctrl_bench.sv
module dma_svc_ctrl_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_i = 0, xfer_done_i = 0, eop_ext_i = 0;
  logic [1:0]  mode_i = 0;
  logic        addr_dec_i = 0, autoinit_i = 0, load_i = 0;
  logic [15:0] base_addr_i = 0, base_cnt_i = 0;
  logic        svc_active_o, tc_o, eop_o, masked_o;
  logic [15:0] cur_addr_o, cur_cnt_o;

  dma_svc_ctrl u_dma_svc_ctrl (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic eop; logic [15:0] addr; logic [15:0] cnt;
    logic svc; logic tc; logic mask; string tag;
  } exp_t;
  exp_t sb[$];
  exp_t pexp;
  bit   pend = 0;
  int   checks = 0, fails = 0;
  logic [15:0] m_addr = 0, m_cnt = 0;
  logic        m_tc = 0, m_mask = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per transfer pulse
  always @(negedge clk) begin
    if (pend) begin
      chk(cur_addr_o == pexp.addr, {pexp.tag, " addr"}, 32'(cur_addr_o), 32'(pexp.addr));
      chk(cur_cnt_o  == pexp.cnt,  {pexp.tag, " cnt"},  32'(cur_cnt_o),  32'(pexp.cnt));
      chk(svc_active_o == pexp.svc, {pexp.tag, " svc"}, 32'(svc_active_o), 32'(pexp.svc));
      chk(tc_o == pexp.tc, {pexp.tag, " tc"}, 32'(tc_o), 32'(pexp.tc));
      chk(masked_o == pexp.mask, {pexp.tag, " mask"}, 32'(masked_o), 32'(pexp.mask));
      pend = 0;
    end
    if (xfer_done_i && sb.size() > 0) begin
      pexp = sb.pop_front();
      chk(eop_o == pexp.eop, {pexp.tag, " eop R7"}, 32'(eop_o), 32'(pexp.eop));
      pend = 1;
    end
  end

  task automatic do_load(input logic [15:0] a, input logic [15:0] c);
    @(posedge clk) #2;
    base_addr_i = a; base_cnt_i = c; load_i = 1;
    @(posedge clk) #2;
    load_i = 0;
    m_addr = a; m_cnt = c; m_tc = 0; m_mask = 0;
  endtask

  task automatic start_svc(input string tag);
    @(posedge clk) #2;
    req_i = 1;
    @(posedge clk) #2;
    chk(svc_active_o == !m_mask, tag, 32'(svc_active_o), 32'(!m_mask));
  endtask

  // driver: computes the expected outcome and pushes it, then pulses done
  task automatic xfer(input bit ext, input bit rq, input string tag);
    exp_t e;
    bit roll, fin;
    @(posedge clk) #2;
    req_i = rq; eop_ext_i = ext;
    roll = (m_cnt == 16'h0000);
    e.eop = roll || ext;
    m_cnt = m_cnt - 16'd1;
    m_addr = addr_dec_i ? m_addr - 16'd1 : m_addr + 16'd1;
    if (e.eop && autoinit_i) begin m_addr = base_addr_i; m_cnt = base_cnt_i; end
    if (roll) begin m_tc = 1; if (!autoinit_i) m_mask = 1; end
    case (mode_i)
      2'b01:   fin = e.eop;
      2'b10:   fin = e.eop || !rq;
      default: fin = 1;
    endcase
    e.addr = m_addr; e.cnt = m_cnt; e.svc = !fin; e.tc = m_tc; e.mask = m_mask; e.tag = tag;
    sb.push_back(e);
    xfer_done_i = 1;
    @(posedge clk) #2;
    xfer_done_i = 0; eop_ext_i = 0;
  endtask

  initial begin
    #(8 * 100000);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #20 rst_n = 1;
    #2;
    // R1 reset state
    chk(!svc_active_o && !eop_o, "R1 svc/eop", {svc_active_o, eop_o}, 0);
    chk(!tc_o && !masked_o, "R1 tc/mask", {tc_o, masked_o}, 0);
    chk(cur_addr_o == 0 && cur_cnt_o == 0, "R1 addr/cnt", {cur_addr_o, cur_cnt_o}, 0);

    // R10 done while idle is ignored
    do_load(16'h1000, 16'd2);
    @(posedge clk) #2; xfer_done_i = 1;
    @(posedge clk) #2; xfer_done_i = 0;
    @(negedge clk);
    chk(cur_addr_o == 16'h1000 && cur_cnt_o == 16'd2 && !svc_active_o,
        "R10 idle done ignored", {cur_addr_o, cur_cnt_o}, {16'h1000, 16'd2});

    // R4 single mode, R2 increment
    mode_i = 2'b00; addr_dec_i = 0; autoinit_i = 0;
    start_svc("R10 start single");
    xfer(0, 1, "R4 single 1");
    start_svc("R10 restart single");
    xfer(0, 0, "R4 single 2");

    // R5 block with request dropped, R2 wrap, R3 rollover, R9 mask
    do_load(16'hFFFE, 16'd2);
    mode_i = 2'b01;
    start_svc("R10 start block");
    xfer(0, 0, "R5 block a");
    xfer(0, 0, "R2 wrap block b");
    xfer(0, 0, "R3 tc block c");
    @(posedge clk) #2; req_i = 1;
    repeat (3) @(posedge clk);
    #2;
    chk(!svc_active_o, "R9 masked ignores req", 32'(svc_active_o), 0);
    req_i = 0;

    // R6 demand, decrement, release and resume
    do_load(16'h2000, 16'd5);
    mode_i = 2'b10; addr_dec_i = 1;
    start_svc("R10 start demand");
    xfer(0, 1, "R6 demand a");
    xfer(0, 1, "R6 demand b");
    xfer(0, 0, "R6 demand release");
    @(posedge clk) #2;
    chk(!svc_active_o && cur_addr_o == 16'h1FFD && cur_cnt_o == 16'd2,
        "R6 kept between services", {cur_addr_o, cur_cnt_o}, {16'h1FFD, 16'd2});
    start_svc("R6 resume");
    xfer(0, 0, "R6 demand resumed");

    // R8 autoinit on external end of process in block mode
    do_load(16'h3000, 16'd7);
    mode_i = 2'b01; addr_dec_i = 0; autoinit_i = 1;
    start_svc("R10 start block auto");
    xfer(0, 0, "R8 block auto a");
    xfer(1, 0, "R8 R7 ext eop reload");

    // R8 autoinit on terminal count in demand mode: no mask
    do_load(16'h4000, 16'd0);
    mode_i = 2'b10;
    start_svc("R10 start demand auto");
    xfer(0, 1, "R8 R3 tc reload");
    start_svc("R9 unmasked with autoinit");
    xfer(0, 0, "R6 demand auto end");

    repeat (3) @(posedge clk);
    chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule